// File: doc/BRIEF.md
# Interlaced Video Timing Generator

This block produces the raster timing for a display pipeline: a data-enable strobe, horizontal sync, vertical sync and a composite sync, plus a field identifier, a one-cycle end-of-field pulse and a one-cycle vertical-sync interrupt pulse. Positions are counted from the top-left pixel of the visible area. Along a line the order is visible pixels, right margin, sync, then left margin. Down a field the order is visible lines, bottom margin, sync lines, then top margin.

In progressive operation every field is identical. In interlaced operation the fields alternate between even and odd. The odd field is one line taller. Its bottom margin is one line longer, and its vertical sync edges fall half a line earlier along the line than those of the even field. The top margin is the same in both fields. The even field places its vertical sync edges at the pixel where horizontal sync starts. All configuration words are plain inputs. They are captured only at the first pixel of a field, so a write made while a field is running takes effect in the following field.

Top module: `ilace_timing_gen`

## Requirements
- R1: While reset is held, deO, hsyncO, vsyncO, csyncO, fieldIdO, fieldDoneO and vsIrqO are all 0.
- R2: A line lasts H = cfgTotal[15:0] cycles. deO is high for the first cfgActive[15:0] pixels of each visible line. Horizontal sync is active from pixel A+R up to, but not including, pixel H-L, where A is the active width, R = cfgHMargin[15:0] and L = cfgHMargin[31:16].
- R3: deO is high only when the pixel is inside the visible columns and inside the first cfgActive[31:16] lines, giving width*height enabled cycles per field.
- R4: With cfgInterlace at 0, a field lasts cfgTotal[31:16] lines and fieldIdO stays 0.
- R5: With cfgInterlace at 1, fieldIdO flips at every field boundary (0 = even, 1 = odd). An odd field lasts cfgTotal[31:16]+1 lines and an even field lasts cfgTotal[31:16] lines.
- R6: In even and progressive fields, vertical sync becomes active at line V+B and becomes inactive at line T-P, where V is the visible height, B = cfgVMargin[15:0], T is the vertical total and P = cfgVMargin[31:16]. Both edges occur at pixel A+R.
- R7: In odd fields, vertical sync becomes active at line V+B+1 and becomes inactive at line T+1-P. Both edges occur at pixel A+R-floor(H/2), so the top margin P is unchanged.
- R8: cfgInvert bit 0 inverts horizontal sync, bit 1 inverts vertical sync and bit 2 inverts composite sync. Without inversion the syncs are active high. Composite sync is active whenever horizontal or vertical sync is active.
- R9: Configuration changes made after a field has started do not alter that field. They apply from the next field onwards, and this includes the interlace enable.
- R10: fieldDoneO is a one-cycle pulse aligned with the last pixel of each field. vsIrqO is a one-cycle pulse in the same cycle in which vertical sync turns active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgTotal | input | 32 | Vertical total [31:16], horizontal total [15:0] |
| cfgActive | input | 32 | Visible height [31:16], visible width [15:0] |
| cfgHMargin | input | 32 | Left margin [31:16], right margin [15:0] |
| cfgVMargin | input | 32 | Top margin [31:16], bottom margin [15:0] |
| cfgInvert | input | 3 | Sync inversion: bit2 composite, bit1 vertical, bit0 horizontal |
| cfgInterlace | input | 1 | 1 selects alternating odd/even fields |
| deO | output | 1 | Data enable |
| hsyncO | output | 1 | Horizontal sync |
| vsyncO | output | 1 | Vertical sync |
| csyncO | output | 1 | Composite sync |
| fieldIdO | output | 1 | Current field, 1 = odd |
| fieldDoneO | output | 1 | Pulse on the last pixel of a field |
| vsIrqO | output | 1 | Pulse when vertical sync turns active |

## Verification
Every output is registered exactly once after the pixel counters. The outputs for pixel (0,0) of a field therefore appear in the cycle after fieldDoneO is seen, and a pixel at line y, column x appears y*H+x cycles after that. The bench samples on the falling edge and numbers each sample from the one after a fieldDone pulse. It compares the first and last index of each sync, enable and pulse against positions that its own functions derive from the configuration that was driven at the moment of that boundary. Configuration is changed only right after a boundary sample, so the field then under way is known to run on the old values.

// File: rtl/vtg_pkg.sv
package vtg_pkg;
  localparam int CNT_W = 16;
  localparam int REG_W = 2 * CNT_W;

  typedef logic [CNT_W-1:0] cnt_t;

  // Geometry of one field, resolved at the field boundary
  typedef struct packed {
    cnt_t hAct;
    cnt_t hTot;
    cnt_t hsStart;
    cnt_t hsEnd;
    cnt_t vAct;
    cnt_t vTot;
    cnt_t vsStart;
    cnt_t vsEnd;
    cnt_t vPos;
    logic invH;
    logic invV;
    logic invC;
  } geom_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic run;
    logic fieldEnd;
    logic oddField;
  } strobe_t;
endpackage

// File: rtl/vtg_ctrl.sv
module vtg_ctrl
  import vtg_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [REG_W-1:0] cfgTotal,
  input  logic [REG_W-1:0] cfgActive,
  input  logic [REG_W-1:0] cfgHMargin,
  input  logic [REG_W-1:0] cfgVMargin,
  input  logic [2:0]       cfgInvert,
  input  logic             cfgInterlace,
  output cnt_t             hCnt,
  output cnt_t             vCnt,
  output geom_t            geom,
  output strobe_t          strb
);
  logic running;
  logic fieldOdd;
  logic lastPix;
  logic lastLine;
  logic nextOdd;

  function automatic geom_t buildGeom(
    input logic [REG_W-1:0] tot,
    input logic [REG_W-1:0] act,
    input logic [REG_W-1:0] hm,
    input logic [REG_W-1:0] vm,
    input logic [2:0]       inv,
    input logic             odd
  );
    geom_t g;
    cnt_t  oddAdd;
    oddAdd    = {{(CNT_W-1){1'b0}}, odd};
    g.hAct    = act[CNT_W-1:0];
    g.hTot    = tot[CNT_W-1:0];
    g.hsStart = act[CNT_W-1:0] + hm[CNT_W-1:0];
    g.hsEnd   = tot[CNT_W-1:0] - hm[REG_W-1:CNT_W];
    g.vAct    = act[REG_W-1:CNT_W];
    g.vTot    = tot[REG_W-1:CNT_W] + oddAdd;
    g.vsStart = act[REG_W-1:CNT_W] + vm[CNT_W-1:0] + oddAdd;
    g.vsEnd   = g.vTot - vm[REG_W-1:CNT_W];
    // odd field: sync edges half a line earlier
    g.vPos    = odd ? (g.hsStart - (g.hTot >> 1)) : g.hsStart;
    g.invH    = inv[0];
    g.invV    = inv[1];
    g.invC    = inv[2];
    return g;
  endfunction

  always_comb begin
    lastPix  = (hCnt == geom.hTot - 1'b1);
    lastLine = (vCnt == geom.vTot - 1'b1);
    nextOdd  = cfgInterlace & ~fieldOdd;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running  <= 1'b0;
      hCnt     <= '0;
      vCnt     <= '0;
      fieldOdd <= 1'b0;
      geom     <= '0;
    end else if (!running) begin
      running  <= 1'b1;
      hCnt     <= '0;
      vCnt     <= '0;
      fieldOdd <= 1'b0;
      geom     <= buildGeom(cfgTotal, cfgActive, cfgHMargin, cfgVMargin,
                            cfgInvert, 1'b0);
    end else if (lastPix) begin
      hCnt <= '0;
      if (lastLine) begin
        vCnt     <= '0;
        fieldOdd <= nextOdd;
        geom     <= buildGeom(cfgTotal, cfgActive, cfgHMargin, cfgVMargin,
                              cfgInvert, nextOdd);
      end else begin
        vCnt <= vCnt + 1'b1;
      end
    end else begin
      hCnt <= hCnt + 1'b1;
    end
  end

  always_comb begin
    strb.run      = running;
    strb.fieldEnd = running & lastPix & lastLine;
    strb.oddField = fieldOdd;
  end
endmodule

// File: rtl/vtg_dpath.sv
module vtg_dpath
  import vtg_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  cnt_t    hCnt,
  input  cnt_t    vCnt,
  input  geom_t   geom,
  input  strobe_t strb,
  output logic    deO,
  output logic    hsyncO,
  output logic    vsyncO,
  output logic    csyncO,
  output logic    fieldIdO,
  output logic    fieldDoneO,
  output logic    vsIrqO
);
  logic hsLvl;
  logic vsLvl;
  logic afterStart;
  logic beforeEnd;
  logic deLvl;
  logic irqHit;

  always_comb begin
    hsLvl      = (hCnt >= geom.hsStart) && (hCnt < geom.hsEnd);
    afterStart = (vCnt > geom.vsStart) ||
                 ((vCnt == geom.vsStart) && (hCnt >= geom.vPos));
    beforeEnd  = (vCnt < geom.vsEnd) ||
                 ((vCnt == geom.vsEnd) && (hCnt < geom.vPos));
    vsLvl      = afterStart && beforeEnd;
    deLvl      = (hCnt < geom.hAct) && (vCnt < geom.vAct);
    irqHit     = (vCnt == geom.vsStart) && (hCnt == geom.vPos);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      deO        <= 1'b0;
      hsyncO     <= 1'b0;
      vsyncO     <= 1'b0;
      csyncO     <= 1'b0;
      fieldIdO   <= 1'b0;
      fieldDoneO <= 1'b0;
      vsIrqO     <= 1'b0;
    end else begin
      deO        <= strb.run & deLvl;
      hsyncO     <= (strb.run & hsLvl) ^ geom.invH;
      vsyncO     <= (strb.run & vsLvl) ^ geom.invV;
      csyncO     <= (strb.run & (hsLvl | vsLvl)) ^ geom.invC;
      fieldIdO   <= strb.oddField;
      fieldDoneO <= strb.fieldEnd;
      vsIrqO     <= strb.run & irqHit;
    end
  end
endmodule

// File: rtl/ilace_timing_gen.sv
module ilace_timing_gen
  import vtg_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [REG_W-1:0] cfgTotal,
  input  logic [REG_W-1:0] cfgActive,
  input  logic [REG_W-1:0] cfgHMargin,
  input  logic [REG_W-1:0] cfgVMargin,
  input  logic [2:0]       cfgInvert,
  input  logic             cfgInterlace,
  output logic             deO,
  output logic             hsyncO,
  output logic             vsyncO,
  output logic             csyncO,
  output logic             fieldIdO,
  output logic             fieldDoneO,
  output logic             vsIrqO
);
  cnt_t    hCnt;
  cnt_t    vCnt;
  geom_t   geom;
  strobe_t strb;

  vtg_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .cfgTotal     (cfgTotal),
    .cfgActive    (cfgActive),
    .cfgHMargin   (cfgHMargin),
    .cfgVMargin   (cfgVMargin),
    .cfgInvert    (cfgInvert),
    .cfgInterlace (cfgInterlace),
    .hCnt         (hCnt),
    .vCnt         (vCnt),
    .geom         (geom),
    .strb         (strb)
  );

  vtg_dpath u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .hCnt       (hCnt),
    .vCnt       (vCnt),
    .geom       (geom),
    .strb       (strb),
    .deO        (deO),
    .hsyncO     (hsyncO),
    .vsyncO     (vsyncO),
    .csyncO     (csyncO),
    .fieldIdO   (fieldIdO),
    .fieldDoneO (fieldDoneO),
    .vsIrqO     (vsIrqO)
  );
endmodule

// File: rtl/vtg_chk.sv
module vtg_chk
  import vtg_pkg::*;
(
  input logic clk,
  input logic rstN,
  input logic deO,
  input logic vsyncO,
  input logic fieldIdO,
  input logic fieldDoneO,
  input logic vsIrqO,
  input logic run,
  input cnt_t hCnt,
  input cnt_t hAct,
  input cnt_t hTot
);
  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    fieldDoneO |=> !fieldDoneO);

  // R10
  irq_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    vsIrqO |-> (vsyncO != $past(vsyncO)));

  // R5
  field_id_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(fieldDoneO) |-> $stable(fieldIdO));

  // R2
  hcount_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    run |-> (hCnt < hTot));

  // R3
  de_column_chk: assert property (@(posedge clk) disable iff (!rstN)
    deO |-> ($past(hCnt) < $past(hAct)));
endmodule

bind ilace_timing_gen vtg_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .deO        (deO),
  .vsyncO     (vsyncO),
  .fieldIdO   (fieldIdO),
  .fieldDoneO (fieldDoneO),
  .vsIrqO     (vsIrqO),
  .run        (strb.run),
  .hCnt       (hCnt),
  .hAct       (geom.hAct),
  .hTot       (geom.hTot)
);

// File: tb/sim_ilace_timing_gen.sv
`timescale 1ns/1ps
module sim_ilace_timing_gen;
  typedef struct {
    int hA, hR, hS, hL;
    int vA, vB, vS, vT;
    bit [2:0] inv;
    bit il;
  } mode_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [31:0] cfgTotal, cfgActive, cfgHMargin, cfgVMargin;
  logic [2:0] cfgInvert;
  logic cfgInterlace;
  logic deO, hsyncO, vsyncO, csyncO, fieldIdO, fieldDoneO, vsIrqO;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  mode_t cur, atBoundary;
  bit lastId;

  always #2.5 clk = ~clk;

  ilace_timing_gen u0 (
    .clk(clk), .rstN(rstN), .cfgTotal(cfgTotal), .cfgActive(cfgActive),
    .cfgHMargin(cfgHMargin), .cfgVMargin(cfgVMargin), .cfgInvert(cfgInvert),
    .cfgInterlace(cfgInterlace), .deO(deO), .hsyncO(hsyncO), .vsyncO(vsyncO),
    .csyncO(csyncO), .fieldIdO(fieldIdO), .fieldDoneO(fieldDoneO),
    .vsIrqO(vsIrqO)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic int hTotal(input mode_t m);
    return m.hA + m.hR + m.hS + m.hL;
  endfunction

  function automatic int vTotal(input mode_t m);
    return m.vA + m.vB + m.vS + m.vT;
  endfunction

  task automatic drive(input mode_t m);
    cfgTotal     = {16'(vTotal(m)), 16'(hTotal(m))};
    cfgActive    = {16'(m.vA), 16'(m.hA)};
    cfgHMargin   = {16'(m.hL), 16'(m.hR)};
    cfgVMargin   = {16'(m.vT), 16'(m.vB)};
    cfgInvert    = m.inv;
    cfgInterlace = m.il;
  endtask

  task automatic setMode(input mode_t m);
    cur = m;
    drive(m);
  endtask

  // Samples one field; index 0 is the sample after the previous fieldDone.
  task automatic measure(input mode_t m, input bit odd, input bit r9);
    int hT, vTf, hsS, hsE, vsS, vsE, vPos;
    int c, deCnt, deLine0, hsRise, hsFall, vsRise, vsFall, irqIdx, irqCnt;
    int idBad, csBad;
    bit hsAct, vsAct, expCs, done;
    string vTag;
    hT   = hTotal(m);
    vTf  = vTotal(m) + int'(odd);
    hsS  = m.hA + m.hR;
    hsE  = hT - m.hL;
    vsS  = m.vA + m.vB + int'(odd);
    vsE  = vTf - m.vT;
    vPos = odd ? hsS - hT / 2 : hsS;
    vTag = odd ? "R7" : "R6";
    c = 0; deCnt = 0; deLine0 = 0; hsRise = -1; hsFall = -1;
    vsRise = -1; vsFall = -1; irqIdx = -1; irqCnt = 0; idBad = 0; csBad = 0;
    done = 0;
    while (!done && c < 5000) begin
      @(negedge clk);
      hsAct = (hsyncO != m.inv[0]);
      vsAct = (vsyncO != m.inv[1]);
      expCs = (hsAct | vsAct) ^ m.inv[2];
      if (deO) deCnt++;
      if (c < hT) begin
        if (deO) deLine0++;
        if (hsAct && hsRise < 0) hsRise = c;
        if (!hsAct && hsRise >= 0 && hsFall < 0) hsFall = c;
      end
      if (vsAct && vsRise < 0) vsRise = c;
      if (!vsAct && vsRise >= 0 && vsFall < 0) vsFall = c;
      if (vsIrqO) begin irqCnt++; if (irqIdx < 0) irqIdx = c; end
      if (fieldIdO != odd) idBad++;
      if (csyncO != expCs) csBad++;
      if (fieldDoneO) done = 1; else c++;
    end
    if (!done) chk("R10", "fieldDone never seen", 0, 1);
    chk(odd ? "R5" : (m.il ? "R5" : "R4"), "field length", c + 1, vTf * hT);
    chk("R3", "enabled cycles per field", deCnt, m.hA * m.vA);
    chk("R2", "enabled pixels in line 0", deLine0, m.hA);
    chk("R2", "hsync start pixel", hsRise, hsS);
    chk("R2", "hsync end pixel", hsFall, hsE);
    chk(vTag, "vsync start index", vsRise, vsS * hT + vPos);
    chk(vTag, "vsync end index", vsFall, vsE * hT + vPos);
    chk("R7", "top margin lines", vTf - vsE, m.vT);
    chk("R10", "irq index", irqIdx, vsS * hT + vPos);
    chk("R10", "irq pulses", irqCnt, 1);
    chk(m.il ? "R5" : "R4", "field id mismatches", idBad, 0);
    chk("R8", "composite sync mismatches", csBad, 0);
    if (r9) chk("R9", "field kept old config length", c + 1, vTf * hT);
  endtask

  task automatic runField(input bit r9);
    mode_t m;
    bit id;
    m  = atBoundary;
    id = m.il ? ~lastId : 1'b0;
    measure(m, id, r9);
    lastId = id;
    atBoundary = cur;
  endtask

  function automatic mode_t randMode();
    mode_t m;
    m.hA = 8 + int'($urandom_range(12));
    m.hR = 1 + int'($urandom_range(3));
    m.hS = 2 + int'($urandom_range(2));
    m.hL = 1 + int'($urandom_range(3));
    m.vA = 2 + int'($urandom_range(8));
    m.vB = 1 + int'($urandom_range(2));
    m.vS = 1 + int'($urandom_range(2));
    m.vT = 1 + int'($urandom_range(2));
    m.inv = 3'($urandom_range(7));
    m.il = 1'($urandom_range(1));
    return m;
  endfunction

  initial begin
    #(200000 * 5);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    mode_t m;
    int guard;
    void'($urandom(32'd4242));
    // 16x8 mode: H=16+3+5+4=28, V=8+2+2+3=15
    m.hA = 16; m.hR = 3; m.hS = 5; m.hL = 4;
    m.vA = 8;  m.vB = 2; m.vS = 2; m.vT = 3;
    m.inv = 3'b000; m.il = 1'b0;
    setMode(m);
    repeat (4) @(negedge clk);
    chk("R1", "de in reset", deO, 0);
    chk("R1", "hsync in reset", hsyncO, 0);
    chk("R1", "vsync in reset", vsyncO, 0);
    chk("R1", "csync in reset", csyncO, 0);
    chk("R1", "field id in reset", fieldIdO, 0);
    chk("R1", "done in reset", fieldDoneO, 0);
    chk("R1", "irq in reset", vsIrqO, 0);
    rstN = 1'b1;
    guard = 0;
    do begin @(negedge clk); guard++; end while (!fieldDoneO && guard < 5000);
    chk("R10", "first field done seen", int'(fieldDoneO), 1);
    lastId = 1'b0;
    atBoundary = cur;
    runField(0);
    runField(0);
    // switch to interlaced: odd field has 16 lines, vsync at pixel 5
    m.il = 1'b1;
    setMode(m);
    runField(1);
    runField(0);
    runField(0);
    runField(0);
    // all sync outputs inverted
    m.inv = 3'b111;
    setMode(m);
    runField(1);
    runField(0);
    runField(0);
    for (int k = 0; k < 8; k++) begin
      setMode(randMode());
      runField(1);
      runField(0);
      runField(0);
    end
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule